// File: doc/BRIEF.md
# Shadow-Tag Victim Cache Directory

This block is the lookup and control logic for a last-level victim cache shared by a cluster of four cores. Each core has a private second-level cache, and the directory keeps a mirror of each core's tags. A request arrives when a core has missed in its own second-level cache. The directory then gives one of three outcomes. The line may be found in the shared cache. It may be fetched from a peer core's second-level cache. Or it may be requested from outside the cluster. For a hit in the shared cache, the directory also decides whether the line stays there or is dropped.

The shared cache is filled only from lines that the second-level caches evict. Each request is treated as a coupled fill/victim step. The requester's mirrored entry at the line's set is replaced by the new line. The line it displaces is reported and written into the shared tags. The mirrored tags also let the directory suppress an outside probe when a line is known to live only inside the cluster. Outside responses are returned to the core as two half-line beats. Each core may have at most 50 requests in flight. A per-core release input returns these credits.

Top module: `vc_directory`

## Requirements
- R1: An accepted request is classified by priority. A hit in the shared tags gives dec_kind 0. Otherwise, a copy in the mirrored tags of any other core gives dec_kind 1. Otherwise dec_kind is 2.
- R2: For dec_kind 1, dec_peer is the lowest-numbered core, other than the requester, whose mirrored tags hold the line.
- R3: For dec_kind 0, dec_keep is 1 when req_ifetch was set or another core's mirrored tags hold the line. When dec_keep is 0 the line is removed from the shared tags, so a later request for it does not hit there. dec_keep is 0 for other kinds.
- R4: dec_probe_ext is 1 only for dec_kind 1 with exactly one other holder. With two or more other holders it is 0.
- R5: The requester's mirrored entry at set req_addr[1:0] takes the request address. If that entry held a different valid line, vic_valid is 1 with vic_addr set to that line, and the line is written into the shared tags at set vic_addr[2:0].
- R6: xreq_valid is 1 with xreq_addr equal to the request address exactly when the decision has dec_kind 2.
- R7: The decision outputs are valid in the cycle after acceptance, and dec_core is the requester. Exactly one decision is produced per accepted request.
- R8: Each core may have at most 50 accepted, unreleased requests. When a core reaches 50, req_ready is low for that core. A rel_valid pulse frees one credit. A release at zero credits has no effect.
- R9: A response accepted on xrsp is sent as two 256-bit beats in the next two cycles. The beat with line bits 255:0 goes first. fill_last is set on the second beat, and fill_core equals xrsp_core. xrsp_ready is low while beats are pending.
- R10: After reset, all tags are empty, req_ready and xrsp_ready are high, and no decision or beat is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted (credit available for req_core) |
| req_core | input | 2 | Requesting core |
| req_addr | input | 16 | Line address |
| req_ifetch | input | 1 | Request comes from instruction fetch |
| rel_valid | input | 1 | Release one credit |
| rel_core | input | 2 | Core whose credit is released |
| dec_valid | output | 1 | Decision valid |
| dec_core | output | 2 | Requester of the decision |
| dec_kind | output | 2 | 0 shared hit, 1 peer transfer, 2 outside miss |
| dec_peer | output | 2 | Source core of a peer transfer |
| dec_keep | output | 1 | Line stays in the shared cache |
| dec_probe_ext | output | 1 | Outside probe needed |
| vic_valid | output | 1 | A victim line was displaced |
| vic_addr | output | 16 | Victim line address |
| xreq_valid | output | 1 | Outside request issued |
| xreq_addr | output | 16 | Outside request line address |
| xrsp_valid | input | 1 | Outside response present |
| xrsp_ready | output | 1 | Outside response may be accepted |
| xrsp_core | input | 2 | Core the response belongs to |
| xrsp_data | input | 512 | Full line data |
| fill_valid | output | 1 | Beat valid |
| fill_core | output | 2 | Destination core of the beat |
| fill_data | output | 256 | Beat data |
| fill_last | output | 1 | Final beat of the line |

## Verification
The bench builds a shared-cache hit on a line that another core also holds, to check that the shared cache wins over a peer transfer. A design with the wrong priority would report a peer transfer for that line. It drops a non-shared, non-fetch hit and then asks for the line again. A design that left the line in place would report a second shared-cache hit where a peer transfer is expected. It also drives a line to one holder and then to two holders, to check probe suppression. It releases credits at zero before filling one core to its limit of 50. A counter that wrapped on that release would let a 51st request through. Swapped beat halves or a misplaced last flag show up as data or flag mismatches on the fill port.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
    localparam int NCORE  = 4;
    localparam int CORE_W = 2;

    typedef enum logic [1:0] {
        OUT_LLC_HIT = 2'd0,
        OUT_PEER    = 2'd1,
        OUT_MISS    = 2'd2
    } outcome_e;

    // lowest-numbered set bit of a core mask
    function automatic logic [CORE_W-1:0] first_core(input logic [NCORE-1:0] m);
        logic [CORE_W-1:0] r;
        r = '0;
        for (int i = NCORE - 1; i >= 0; i--) begin
            if (m[i]) r = CORE_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vcd_shadow.sv
module vcd_shadow
    import vcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    lk_addr,
    input  logic [CORE_W-1:0]    lk_core,
    input  logic                 wr_en,
    output logic [NCORE-1:0]     hold_mask,
    output logic                 vic_vld,
    output logic [ADDR_W-1:0]    vic_addr
);
    localparam int IW = $clog2(SETS);

    logic [IW-1:0] idx;
    logic [NCORE-1:0] ent_v;
    logic [NCORE-1:0][ADDR_W-1:0] ent_a;

    assign idx = lk_addr[IW-1:0];

    for (genvar k = 0; k < NCORE; k++) begin : g_core
        logic [SETS-1:0] vld;
        logic [SETS-1:0][ADDR_W-1:0] tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= '0;
            end else if (wr_en && lk_core == CORE_W'(k)) begin
                vld[idx] <= 1'b1;
                tag[idx] <= lk_addr;
            end
        end

        assign ent_v[k]     = vld[idx];
        assign ent_a[k]     = tag[idx];
        assign hold_mask[k] = vld[idx] && (tag[idx] == lk_addr);
    end

    assign vic_vld  = ent_v[lk_core] && (ent_a[lk_core] != lk_addr);
    assign vic_addr = ent_a[lk_core];
endmodule

// File: rtl/vcd_llc_tags.sv
module vcd_llc_tags #(
    parameter int ADDR_W = 16,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    input  logic              drop_en,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr
);
    localparam int IW = $clog2(SETS);

    logic [SETS-1:0] vld;
    logic [SETS-1:0][ADDR_W-1:0] tag;
    logic [IW-1:0] lidx, iidx;

    assign lidx = lk_addr[IW-1:0];
    assign iidx = ins_addr[IW-1:0];
    assign hit  = vld[lidx] && (tag[lidx] == lk_addr);

    // insertion is the newer event and wins when both hit one set
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (drop_en) vld[lidx] <= 1'b0;
            if (ins_en) begin
                vld[iidx] <= 1'b1;
                tag[iidx] <= ins_addr;
            end
        end
    end
endmodule

// File: rtl/vcd_credit.sv
module vcd_credit #(
    parameter int MAX_OUT = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic full
);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign full = (cnt == CW'(MAX_OUT));
endmodule

// File: rtl/vcd_beats.sv
module vcd_beats #(
    parameter int LINE_W = 512,
    parameter int BEAT_W = 256,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CORE_W-1:0] in_core,
    input  logic [LINE_W-1:0] in_data,
    output logic              out_valid,
    output logic [CORE_W-1:0] out_core,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last
);
    localparam int NB = LINE_W / BEAT_W;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;

    logic              busy;
    logic [BW-1:0]     cnt;
    logic [LINE_W-1:0] line_q;
    logic [CORE_W-1:0] core_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy   <= 1'b1;
                cnt    <= '0;
                line_q <= in_data;
                core_q <= in_core;
            end
        end else if (out_last) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign in_ready  = !busy;
    assign out_valid = busy;
    assign out_core  = core_q;
    assign out_last  = busy && (cnt == BW'(NB - 1));
    assign out_data  = line_q[int'(cnt) * BEAT_W +: BEAT_W];
endmodule

// File: rtl/vc_directory.sv
module vc_directory
    import vcd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int L2_SETS    = 4,
    parameter int LLC_SETS   = 8,
    parameter int MAX_OUT    = 50,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_core,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_ifetch,
    input  logic                    rel_valid,
    input  logic [1:0]              rel_core,
    output logic                    dec_valid,
    output logic [1:0]              dec_core,
    output logic [1:0]              dec_kind,
    output logic [1:0]              dec_peer,
    output logic                    dec_keep,
    output logic                    dec_probe_ext,
    output logic                    vic_valid,
    output logic [ADDR_W-1:0]       vic_addr,
    output logic                    xreq_valid,
    output logic [ADDR_W-1:0]       xreq_addr,
    input  logic                    xrsp_valid,
    output logic                    xrsp_ready,
    input  logic [1:0]              xrsp_core,
    input  logic [LINE_BYTES*8-1:0] xrsp_data,
    output logic                    fill_valid,
    output logic [1:0]              fill_core,
    output logic [BEAT_BYTES*8-1:0] fill_data,
    output logic                    fill_last
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEAT_W = BEAT_BYTES * 8;

    typedef struct packed {
        logic              vld;
        logic [1:0]        core;
        outcome_e          kind;
        logic [1:0]        peer;
        logic              keep;
        logic              probe;
        logic              vic;
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] addr;
    } decision_t;

    logic [NCORE-1:0] hold, others, full;
    logic             accept, llc_hit, sh_vic;
    logic [ADDR_W-1:0] sh_vaddr;
    decision_t        nxt, cur;

    assign req_ready = !full[req_core];
    assign accept    = req_valid && req_ready;

    vcd_shadow #(.ADDR_W(ADDR_W), .SETS(L2_SETS)) u_shadow (
        .clk(clk), .rst(rst), .lk_addr(req_addr), .lk_core(req_core),
        .wr_en(accept), .hold_mask(hold), .vic_vld(sh_vic), .vic_addr(sh_vaddr)
    );

    vcd_llc_tags #(.ADDR_W(ADDR_W), .SETS(LLC_SETS)) u_llc (
        .clk(clk), .rst(rst), .lk_addr(req_addr), .hit(llc_hit),
        .drop_en(accept && llc_hit && !nxt.keep),
        .ins_en(accept && sh_vic), .ins_addr(sh_vaddr)
    );

    for (genvar k = 0; k < NCORE; k++) begin : g_cred
        vcd_credit #(.MAX_OUT(MAX_OUT)) u_cred (
            .clk(clk), .rst(rst),
            .inc(accept && req_core == CORE_W'(k)),
            .dec(rel_valid && rel_core == CORE_W'(k)),
            .full(full[k])
        );
    end

    always_comb begin
        others     = hold & ~(NCORE'(1) << req_core);
        nxt        = '0;
        nxt.vld    = accept;
        nxt.core   = req_core;
        nxt.addr   = req_addr;
        nxt.vic    = sh_vic;
        nxt.vaddr  = sh_vaddr;
        if (llc_hit) begin
            nxt.kind = OUT_LLC_HIT;
            nxt.keep = req_ifetch || (others != '0);
        end else if (others != '0) begin
            nxt.kind  = OUT_PEER;
            nxt.peer  = first_core(others);
            nxt.probe = ($countones(others) == 1);
        end else begin
            nxt.kind = OUT_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign dec_valid     = cur.vld;
    assign dec_core      = cur.core;
    assign dec_kind      = cur.kind;
    assign dec_peer      = cur.peer;
    assign dec_keep      = cur.keep;
    assign dec_probe_ext = cur.probe;
    assign vic_valid     = cur.vld && cur.vic;
    assign vic_addr      = cur.vaddr;
    assign xreq_valid    = cur.vld && cur.kind == OUT_MISS;
    assign xreq_addr     = cur.addr;

    vcd_beats #(.LINE_W(LINE_W), .BEAT_W(BEAT_W), .CORE_W(CORE_W)) u_beats (
        .clk(clk), .rst(rst),
        .in_valid(xrsp_valid), .in_ready(xrsp_ready), .in_core(xrsp_core), .in_data(xrsp_data),
        .out_valid(fill_valid), .out_core(fill_core), .out_data(fill_data), .out_last(fill_last)
    );
endmodule

// File: rtl/vcd_checker.sv
module vcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       dec_valid,
    input logic [1:0] dec_core,
    input logic [1:0] dec_kind,
    input logic [1:0] dec_peer,
    input logic       dec_keep,
    input logic       dec_probe_ext,
    input logic       xreq_valid,
    input logic       xrsp_ready,
    input logic       fill_valid,
    input logic [1:0] fill_core,
    input logic       fill_last
);
    // R1
    kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> dec_kind != 2'd3);
    // R2
    peer_not_self_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind == 2'd1) |-> dec_peer != dec_core);
    // R3
    keep_only_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_keep) |-> dec_kind == 2'd0);
    // R4
    probe_only_peer_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_probe_ext) |-> dec_kind == 2'd1);
    // R6
    xreq_match_chk: assert property (@(posedge clk) disable iff (rst)
        xreq_valid |-> (dec_valid && dec_kind == 2'd2));
    // R6
    miss_sends_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind == 2'd2) |-> xreq_valid);
    // R8
    stall_no_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_ready)) |=> !dec_valid);
    // R9
    beat_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_last) |=> (fill_valid && fill_last && $stable(fill_core)));
    // R9
    rsp_block_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !xrsp_ready);
endmodule

bind vc_directory vcd_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .dec_valid(dec_valid), .dec_core(dec_core), .dec_kind(dec_kind), .dec_peer(dec_peer),
    .dec_keep(dec_keep), .dec_probe_ext(dec_probe_ext), .xreq_valid(xreq_valid),
    .xrsp_ready(xrsp_ready), .fill_valid(fill_valid), .fill_core(fill_core), .fill_last(fill_last)
);

// File: tb/tb_vc_directory.sv
`timescale 1ns/1ps
module tb_vc_directory;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic req_valid = 0, req_ifetch = 0, rel_valid = 0, xrsp_valid = 0;
    logic [1:0] req_core = 0, rel_core = 0, xrsp_core = 0;
    logic [15:0] req_addr = 0;
    logic [511:0] xrsp_data = '0;
    logic req_ready, dec_valid, dec_keep, dec_probe_ext, vic_valid, xreq_valid;
    logic xrsp_ready, fill_valid, fill_last;
    logic [1:0] dec_core, dec_kind, dec_peer, fill_core;
    logic [15:0] vic_addr, xreq_addr;
    logic [255:0] fill_data;

    vc_directory dut (.*);

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct {
        int core; int kind; int peer; bit keep; bit probe;
        bit vic; logic [15:0] vaddr; logic [15:0] addr;
    } exp_t;
    exp_t q[$];

    logic [15:0] m_sh [4][4];
    bit          m_shv[4][4];
    logic [15:0] m_llc [8];
    bit          m_llcv[8];
    int          m_cred[4];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_req(int c, logic [15:0] a, bit f);
        exp_t e;
        int i, li, n;
        logic [3:0] oth;
        bit hit;
        i = int'(a[1:0]); li = int'(a[2:0]);
        oth = '0; n = 0;
        for (int k = 0; k < 4; k++)
            if (k != c && m_shv[k][i] && m_sh[k][i] == a) begin oth[k] = 1; n++; end
        hit = m_llcv[li] && m_llc[li] == a;
        e.core = c; e.addr = a; e.peer = 0; e.keep = 0; e.probe = 0;
        if (hit) begin e.kind = 0; e.keep = f || (n > 0); end
        else if (n > 0) begin
            e.kind = 1; e.probe = (n == 1);
            for (int k = 3; k >= 0; k--) if (oth[k]) e.peer = k;
        end else e.kind = 2;
        e.vic = m_shv[c][i] && m_sh[c][i] != a;
        e.vaddr = m_sh[c][i];
        @(negedge clk);
        req_valid = 1; req_core = 2'(c); req_addr = a; req_ifetch = f;
        #1;
        chk(req_ready == (m_cred[c] < 50), "R8", "req_ready", req_ready, m_cred[c] < 50);
        if (hit && !e.keep) m_llcv[li] = 0;
        m_sh[c][i] = a; m_shv[c][i] = 1;
        if (e.vic) begin m_llc[e.vaddr[2:0]] = e.vaddr; m_llcv[e.vaddr[2:0]] = 1; end
        m_cred[c]++;
        q.push_back(e);
        @(negedge clk);
        req_valid = 0; req_ifetch = 0;
    endtask

    task automatic rel(int c);
        @(negedge clk);
        rel_valid = 1; rel_core = 2'(c);
        if (m_cred[c] > 0) m_cred[c]--;
        @(negedge clk);
        rel_valid = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            if (q.size() == 0) chk(0, "R7", "unexpected decision", 1, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk(dec_core == 2'(e.core), "R7", "dec_core", dec_core, e.core);
                chk(dec_kind == 2'(e.kind), "R1", "dec_kind", dec_kind, e.kind);
                if (e.kind == 1) chk(dec_peer == 2'(e.peer), "R2", "dec_peer", dec_peer, e.peer);
                chk(dec_keep == e.keep, "R3", "dec_keep", dec_keep, e.keep);
                chk(dec_probe_ext == e.probe, "R4", "dec_probe_ext", dec_probe_ext, e.probe);
                chk(vic_valid == e.vic, "R5", "vic_valid", vic_valid, e.vic);
                if (e.vic) chk(vic_addr == e.vaddr, "R5", "vic_addr", vic_addr, e.vaddr);
                chk(xreq_valid == (e.kind == 2), "R6", "xreq_valid", xreq_valid, e.kind == 2);
                if (e.kind == 2) chk(xreq_addr == e.addr, "R6", "xreq_addr", xreq_addr, e.addr);
            end
        end
    end

    task automatic send_rsp(int c, logic [511:0] d);
        @(negedge clk);
        chk(xrsp_ready == 1, "R9", "xrsp_ready idle", xrsp_ready, 1);
        xrsp_valid = 1; xrsp_core = 2'(c); xrsp_data = d;
        @(negedge clk);
        xrsp_valid = 0;
        chk(fill_valid && !fill_last && fill_core == 2'(c), "R9", "beat0 ctl",
            {fill_valid, fill_last, fill_core}, {1'b1, 1'b0, 2'(c)});
        chk(fill_data == d[255:0], "R9", "beat0 data", fill_data[63:0], d[63:0]);
        chk(xrsp_ready == 0, "R9", "xrsp_ready busy", xrsp_ready, 0);
        @(negedge clk);
        chk(fill_valid && fill_last && fill_core == 2'(c), "R9", "beat1 ctl",
            {fill_valid, fill_last, fill_core}, {1'b1, 1'b1, 2'(c)});
        chk(fill_data == d[511:256], "R9", "beat1 data", fill_data[63:0], d[319:256]);
        @(negedge clk);
        chk(!fill_valid && xrsp_ready, "R9", "beats done", {fill_valid, xrsp_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_cred[k] = 0;
            for (int s = 0; s < 4; s++) m_shv[k][s] = 0;
        end
        for (int s = 0; s < 8; s++) m_llcv[s] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && xrsp_ready && !dec_valid && !fill_valid, "R10", "reset state",
            {req_ready, xrsp_ready, dec_valid, fill_valid}, 4'b1100);

        // directed: miss, single-holder peer, two-holder peer
        do_req(0, 16'h0010, 0);       // R6 miss
        do_req(1, 16'h0010, 0);       // R4 probe with one holder
        do_req(2, 16'h0010, 0);       // R2/R4 lowest peer, no probe
        // R5 victim: core0 displaces 0x0010 into shared tags
        do_req(0, 16'h0020, 0);
        // R1 shared hit beats peer copies; R3 kept since shared
        do_req(3, 16'h0010, 0);
        // R3 drop: private line hit without fetch
        do_req(0, 16'h0031, 0);
        do_req(0, 16'h0041, 0);       // 0x0031 into shared tags
        do_req(1, 16'h0031, 0);       // hit, keep=0, dropped
        do_req(2, 16'h0031, 0);       // now peer, not hit
        // R3 instruction fetch keeps
        do_req(0, 16'h0052, 0);
        do_req(0, 16'h0062, 0);
        do_req(1, 16'h0052, 1);       // hit, keep=1
        do_req(2, 16'h0052, 0);       // still hit

        // R9 beat sequencing
        send_rsp(2, {64'h8888, 192'h0, 64'h7777, 64'h1111, 128'h0, 64'h2222});
        send_rsp(1, {256'hABCD, 256'h1234});

        // R8: release at zero ignored, then limit of exactly 50
        while (m_cred[2] > 0) rel(2);
        rel(2);
        while (m_cred[2] < 50) do_req(2, 16'(16'h0100 + m_cred[2]), 0);
        @(negedge clk);
        req_valid = 1; req_core = 2'd2; req_addr = 16'h0200;
        #1 chk(req_ready == 0, "R8", "full ready", req_ready, 0);
        @(negedge clk);
        req_valid = 0;
        chk(dec_valid == 0, "R8", "no decision when full", dec_valid, 0);
        rel(2);
        @(negedge clk);
        req_core = 2'd2;
        #1 chk(req_ready == 1, "R8", "ready after release", req_ready, 1);

        // mixed patterns
        for (int t = 0; t < 400; t++) begin
            int c;
            c = $urandom_range(0, 3);
            if (m_cred[c] >= 50) rel(c);
            do_req(c, 16'($urandom_range(0, 31)), bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) rel($urandom_range(0, 3));
        end

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R7", "pending decisions", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule